// File: doc/BRIEF.md
# Out-of-Order Issue Window with Result Broadcast

This block is the scheduling core of a dynamically scheduled pipeline. It accepts decoded operations from an in-order operation queue and parks each one in a free reservation station. At the same time it renames the destination register to that station's tag. Each source operand is captured in one of two ways. If no older instruction is still due to write the register, the value comes straight from the register file. Otherwise the station records the tag of the station that will produce the value.

Completed results come back on a single broadcast result bus, one per cycle, carrying a tag and a value. Every waiting station that holds the matching tag takes the value. The register file write port is driven only when the register's status entry still names that tag, so an older result never overwrites a younger rename. A station whose operands are both present goes to an execution unit. When several stations qualify, the one that was issued first goes. The station stays occupied until its own tag appears on the result bus.

Stores use the same stations. The second source carries the data to be stored, and a store claims no destination register. The address field is held and passed along unchanged.

Top module: `tomasulo_rs_core`

## Requirements
- R1: `iss_ready` is high exactly when at least one station is not busy. A cycle with `iss_valid` and `iss_ready` both high issues into the lowest-numbered free station, whose tag (station index plus one) is shown on `iss_tag` in that same cycle. With `iss_ready` low, nothing is issued.
- R2: A tag value of 0 means the operand value is present. At issue, a source whose register status is blank takes `rf_val1`/`rf_val2` with tag 0. Otherwise it takes the status tag.
- R3: If the result bus broadcasts, in the issue cycle, the tag that a source's status names, that source takes `cdb_value` with tag 0 at issue.
- R4: A non-store issue sets the destination's status entry to the new tag, replacing any older tag. A store (`iss_store`=1) leaves the status table unchanged.
- R5: On a broadcast with a non-zero tag, `rf_we` is high in that cycle with `rf_waddr` equal to the register whose status entry equals the tag and `rf_wdata`=`cdb_value`. That entry then becomes blank. When no entry matches, `rf_we` stays low.
- R6: On a broadcast, every busy station with a pending source tag equal to the broadcast tag stores `cdb_value` in that operand and clears its tag.
- R7: A station is eligible when it is busy, both tags are 0, and it has not yet been dispatched. `disp_valid` is high whenever one is eligible. `disp_tag` then names the eligible station issued earliest, and each station is dispatched once.
- R8: A station stays busy until its own tag is broadcast, and it is free for issue from the next cycle.
- R9: `disp_op`, `disp_vj`, `disp_vk` and `disp_addr` present the dispatched station's operation, operand values and address field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Operation queue head is valid |
| iss_op | input | 3 | Operation code |
| iss_dst | input | 3 | Destination register (ignored for stores) |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register (store data for stores) |
| iss_store | input | 1 | Operation is a store |
| iss_addr | input | 8 | Address information held by the station |
| rf_val1 | input | 16 | Register file value of `iss_src1` |
| rf_val2 | input | 16 | Register file value of `iss_src2` |
| iss_ready | output | 1 | A station is free |
| iss_tag | output | 3 | Tag that the issue in this cycle takes |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | 3 | Producing station tag |
| cdb_value | input | 16 | Result value |
| disp_valid | output | 1 | A station is dispatched this cycle |
| disp_tag | output | 3 | Tag of dispatched station |
| disp_op | output | 3 | Its operation |
| disp_vj | output | 16 | Its first operand |
| disp_vk | output | 16 | Its second operand |
| disp_addr | output | 8 | Its address field |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write address |
| rf_wdata | output | 16 | Register file write data |

## Verification
The hardest case to reach is a single cycle in which a result is broadcast, a new instruction issues and reads the very register that result is renamed to, and possibly renames that same register again. Only then do the issue bypass and the clear-versus-overwrite priority of the status table matter. The bench makes this happen often through several settings together. It uses only eight registers with random sources and destinations, and it lets the execution stubs finish with varying latencies. It also issues on most cycles, so that results retire while the queue keeps pressing. A reference model checks the operands seen at dispatch and each register write against its own rename bookkeeping.

// File: rtl/tomasulo_pkg.sv
package tomasulo_pkg;
    parameter int RS_COUNT  = 4;
    parameter int REG_COUNT = 8;
    parameter int DATA_W    = 16;
    parameter int OP_W      = 3;
    parameter int ADDR_W    = 8;

    localparam int TAG_W = $clog2(RS_COUNT + 1);
    localparam int IDX_W = (RS_COUNT > 1) ? $clog2(RS_COUNT) : 1;
    localparam int REG_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [REG_W-1:0]  reg_t;

    localparam tag_t NO_TAG = '0;

    typedef struct packed {
        logic              busy;
        logic              sent;
        logic [OP_W-1:0]   op;
        data_t             vj;
        data_t             vk;
        tag_t              qj;
        tag_t              qk;
        logic [ADDR_W-1:0] addr;
    } rs_entry_t;

    typedef struct packed {
        tag_t  q;
        data_t v;
    } operand_t;

    function automatic tag_t slot_tag(int idx);
        return tag_t'(idx + 1);
    endfunction

    // Source capture at issue: register file, same-cycle broadcast, or wait on tag
    function automatic operand_t resolve_src(tag_t pending, data_t rf_val,
                                             logic bc_valid, tag_t bc_tag, data_t bc_val);
        operand_t o;
        if (pending == NO_TAG) begin
            o.q = NO_TAG;
            o.v = rf_val;
        end else if (bc_valid && bc_tag == pending) begin
            o.q = NO_TAG;
            o.v = bc_val;
        end else begin
            o.q = pending;
            o.v = '0;
        end
        return o;
    endfunction
endpackage

// File: rtl/rs_station.sv
module rs_station
    import tomasulo_pkg::*;
#(
    parameter tag_t MY_TAG = tag_t'(1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      alloc,
    input  rs_entry_t new_entry,
    input  logic      cdb_valid,
    input  tag_t      cdb_tag,
    input  data_t     cdb_value,
    input  logic      chosen,
    output rs_entry_t entry
);
    rs_entry_t nxt;

    always_comb begin
        nxt = entry;
        if (alloc) begin
            nxt = new_entry;
        end else begin
            if (cdb_valid && entry.busy) begin
                if (entry.qj != NO_TAG && entry.qj == cdb_tag) begin
                    nxt.vj = cdb_value;
                    nxt.qj = NO_TAG;
                end
                if (entry.qk != NO_TAG && entry.qk == cdb_tag) begin
                    nxt.vk = cdb_value;
                    nxt.qk = NO_TAG;
                end
                if (cdb_tag == MY_TAG) begin
                    nxt.busy = 1'b0;
                end
            end
            if (chosen) begin
                nxt.sent = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) entry <= '0;
        else     entry <= nxt;
    end

    AST_CAPTURE_J: assert property (@(posedge clk) disable iff (rst)
        (!alloc && entry.busy && cdb_valid && entry.qj != NO_TAG && entry.qj == cdb_tag)
        |=> (entry.qj == NO_TAG && entry.vj == $past(cdb_value))); // R6
    AST_CAPTURE_K: assert property (@(posedge clk) disable iff (rst)
        (!alloc && entry.busy && cdb_valid && entry.qk != NO_TAG && entry.qk == cdb_tag)
        |=> (entry.qk == NO_TAG && entry.vk == $past(cdb_value))); // R6
    AST_FREE_ON_OWN_TAG: assert property (@(posedge clk) disable iff (rst)
        (!alloc && entry.busy && cdb_valid && cdb_tag == MY_TAG) |=> !entry.busy); // R8
    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (entry.busy && !(cdb_valid && cdb_tag == MY_TAG)) |=> entry.busy); // R8
endmodule

// File: rtl/rs_status.sv
module rs_status
    import tomasulo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  reg_t  wr_reg,
    input  tag_t  wr_tag,
    input  reg_t  rd1,
    input  reg_t  rd2,
    output tag_t  stat1,
    output tag_t  stat2,
    input  logic  cdb_valid,
    input  tag_t  cdb_tag,
    output logic  rf_we,
    output reg_t  rf_waddr
);
    tag_t tab [REG_COUNT];

    assign stat1 = tab[rd1];
    assign stat2 = tab[rd2];

    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = '0;
        for (int r = 0; r < REG_COUNT; r++) begin
            if (cdb_valid && cdb_tag != NO_TAG && tab[r] == cdb_tag) begin
                rf_we    = 1'b1;
                rf_waddr = reg_t'(r);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < REG_COUNT; r++) begin
            if (rst)
                tab[r] <= NO_TAG;
            else if (wr_en && wr_reg == reg_t'(r))
                tab[r] <= wr_tag;
            else if (cdb_valid && cdb_tag != NO_TAG && tab[r] == cdb_tag)
                tab[r] <= NO_TAG;
        end
    end

    AST_RENAME_DST: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tab[$past(wr_reg)] == $past(wr_tag))); // R4
    AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (rf_we && !(wr_en && wr_reg == rf_waddr)) |=> (tab[$past(rf_waddr)] == NO_TAG)); // R5
endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick
    import tomasulo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                alloc_en,
    input  logic [IDX_W-1:0]    alloc_idx,
    input  logic [RS_COUNT-1:0] elig,
    output logic                sel_valid,
    output logic [IDX_W-1:0]    sel_idx
);
    // older[i][j] set: station i entered before station j
    logic [RS_COUNT-1:0] older [RS_COUNT];
    logic [RS_COUNT-1:0] win;

    always_comb begin
        for (int i = 0; i < RS_COUNT; i++) begin
            win[i] = elig[i];
            for (int j = 0; j < RS_COUNT; j++) begin
                if (j != i && elig[j] && older[j][i]) win[i] = 1'b0;
            end
        end
        sel_idx = '0;
        for (int i = RS_COUNT - 1; i >= 0; i--) begin
            if (win[i]) sel_idx = IDX_W'(i);
        end
        sel_valid = |elig;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < RS_COUNT; i++) begin
            for (int j = 0; j < RS_COUNT; j++) begin
                if (rst)
                    older[i][j] <= 1'b0;
                else if (alloc_en && alloc_idx == IDX_W'(j) && i != j)
                    older[i][j] <= 1'b1;
                else if (alloc_en && alloc_idx == IDX_W'(i))
                    older[i][j] <= 1'b0;
            end
        end
    end

    AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win)); // R7
    AST_WINNER_EXISTS: assert property (@(posedge clk) disable iff (rst)
        (|elig) |-> (|win)); // R7
endmodule

// File: rtl/tomasulo_rs_core.sv
module tomasulo_rs_core
    import tomasulo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iss_valid,
    input  logic [OP_W-1:0]      iss_op,
    input  logic [REG_W-1:0]     iss_dst,
    input  logic [REG_W-1:0]     iss_src1,
    input  logic [REG_W-1:0]     iss_src2,
    input  logic                 iss_store,
    input  logic [ADDR_W-1:0]    iss_addr,
    input  logic [DATA_W-1:0]    rf_val1,
    input  logic [DATA_W-1:0]    rf_val2,
    output logic                 iss_ready,
    output logic [TAG_W-1:0]     iss_tag,
    input  logic                 cdb_valid,
    input  logic [TAG_W-1:0]     cdb_tag,
    input  logic [DATA_W-1:0]    cdb_value,
    output logic                 disp_valid,
    output logic [TAG_W-1:0]     disp_tag,
    output logic [OP_W-1:0]      disp_op,
    output logic [DATA_W-1:0]    disp_vj,
    output logic [DATA_W-1:0]    disp_vk,
    output logic [ADDR_W-1:0]    disp_addr,
    output logic                 rf_we,
    output logic [REG_W-1:0]     rf_waddr,
    output logic [DATA_W-1:0]    rf_wdata
);
    rs_entry_t           entries [RS_COUNT];
    logic [RS_COUNT-1:0] busy_vec;
    logic [RS_COUNT-1:0] elig;
    logic [IDX_W-1:0]    alloc_idx;
    logic [IDX_W-1:0]    sel_idx;
    logic                sel_valid;
    logic                fire;
    tag_t                stat1, stat2;
    rs_entry_t           new_entry;
    operand_t            op_j, op_k;

    always_comb begin
        alloc_idx = '0;
        for (int i = RS_COUNT - 1; i >= 0; i--) begin
            if (!busy_vec[i]) alloc_idx = IDX_W'(i);
        end
    end

    assign iss_ready = ~&busy_vec;
    assign iss_tag   = tag_t'(alloc_idx) + tag_t'(1);
    assign fire      = iss_valid && iss_ready;

    rs_status u_status (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (fire && !iss_store),
        .wr_reg   (iss_dst),
        .wr_tag   (iss_tag),
        .rd1      (iss_src1),
        .rd2      (iss_src2),
        .stat1    (stat1),
        .stat2    (stat2),
        .cdb_valid(cdb_valid),
        .cdb_tag  (cdb_tag),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr)
    );
    assign rf_wdata = cdb_value;

    always_comb begin
        op_j = resolve_src(stat1, rf_val1, cdb_valid, cdb_tag, cdb_value);
        op_k = resolve_src(stat2, rf_val2, cdb_valid, cdb_tag, cdb_value);
        new_entry      = '0;
        new_entry.busy = 1'b1;
        new_entry.op   = iss_op;
        new_entry.addr = iss_addr;
        new_entry.vj   = op_j.v;
        new_entry.qj   = op_j.q;
        new_entry.vk   = op_k.v;
        new_entry.qk   = op_k.q;
    end

    for (genvar g = 0; g < RS_COUNT; g++) begin : g_station
        rs_station #(.MY_TAG(slot_tag(g))) u_station (
            .clk      (clk),
            .rst      (rst),
            .alloc    (fire && alloc_idx == IDX_W'(g)),
            .new_entry(new_entry),
            .cdb_valid(cdb_valid),
            .cdb_tag  (cdb_tag),
            .cdb_value(cdb_value),
            .chosen   (sel_valid && sel_idx == IDX_W'(g)),
            .entry    (entries[g])
        );
        assign busy_vec[g] = entries[g].busy;
        assign elig[g]     = entries[g].busy && !entries[g].sent &&
                             entries[g].qj == NO_TAG && entries[g].qk == NO_TAG;
    end

    rs_oldest_pick u_pick (
        .clk      (clk),
        .rst      (rst),
        .alloc_en (fire),
        .alloc_idx(alloc_idx),
        .elig     (elig),
        .sel_valid(sel_valid),
        .sel_idx  (sel_idx)
    );

    assign disp_valid = sel_valid;
    assign disp_tag   = tag_t'(sel_idx) + tag_t'(1);
    assign disp_op    = entries[sel_idx].op;
    assign disp_vj    = entries[sel_idx].vj;
    assign disp_vk    = entries[sel_idx].vk;
    assign disp_addr  = entries[sel_idx].addr;

    AST_ALLOC_TAKES_FREE: assert property (@(posedge clk) disable iff (rst)
        fire |=> busy_vec[$past(alloc_idx)]); // R1
    AST_WRITE_NEEDS_BROADCAST: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (cdb_valid && cdb_tag != NO_TAG)); // R5
    AST_DISPATCH_ONCE: assert property (@(posedge clk) disable iff (rst)
        disp_valid |=> !(disp_valid && disp_tag == $past(disp_tag))); // R7
endmodule

// File: tb/test_tomasulo_rs_core.sv
`timescale 1ns/1ps
module test_tomasulo_rs_core;
    import tomasulo_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              iss_valid = 0, iss_store = 0;
    logic [OP_W-1:0]   iss_op = '0;
    logic [REG_W-1:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [ADDR_W-1:0] iss_addr = '0;
    logic [DATA_W-1:0] rf_val1, rf_val2;
    logic              iss_ready;
    logic [TAG_W-1:0]  iss_tag;
    logic              cdb_valid = 0;
    logic [TAG_W-1:0]  cdb_tag = '0;
    logic [DATA_W-1:0] cdb_value = '0;
    logic              disp_valid;
    logic [TAG_W-1:0]  disp_tag;
    logic [OP_W-1:0]   disp_op;
    logic [DATA_W-1:0] disp_vj, disp_vk;
    logic [ADDR_W-1:0] disp_addr;
    logic              rf_we;
    logic [REG_W-1:0]  rf_waddr;
    logic [DATA_W-1:0] rf_wdata;

    tomasulo_rs_core i_tomasulo_rs_core (.*);

    // Reference model state (index 0 unused for tags)
    logic [DATA_W-1:0] rf [REG_COUNT];
    int          m_stat [REG_COUNT];
    bit          m_busy [1:RS_COUNT];
    bit          m_sent [1:RS_COUNT];
    int          m_op   [1:RS_COUNT];
    int          m_addr [1:RS_COUNT];
    logic [DATA_W-1:0] m_vj [1:RS_COUNT];
    logic [DATA_W-1:0] m_vk [1:RS_COUNT];
    int          m_qj   [1:RS_COUNT];
    int          m_qk   [1:RS_COUNT];
    int          m_seq  [1:RS_COUNT];
    int          m_cd   [1:RS_COUNT];   // -1: not executing
    logic [DATA_W-1:0] m_res [1:RS_COUNT];
    int          seq_ctr = 0;

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < REG_COUNT; r++) begin
            m_stat[r] = 0;
            rf[r] = DATA_W'(16'h100 + r);
        end
        for (int t = 1; t <= RS_COUNT; t++) begin
            m_busy[t] = 0; m_sent[t] = 0; m_cd[t] = -1;
        end
    endtask

    function automatic int exp_free();
        for (int t = 1; t <= RS_COUNT; t++) if (!m_busy[t]) return t;
        return 0;
    endfunction

    function automatic int exp_disp();
        int best = 0;
        for (int t = 1; t <= RS_COUNT; t++)
            if (m_busy[t] && !m_sent[t] && m_qj[t] == 0 && m_qk[t] == 0)
                if (best == 0 || m_seq[t] < m_seq[best]) best = t;
        return best;
    endfunction

    function automatic int exp_wreg();
        if (!cdb_valid) return -1;
        for (int r = 0; r < REG_COUNT; r++) if (m_stat[r] == int'(cdb_tag)) return r;
        return -1;
    endfunction

    task automatic drive(bit allow_issue);
        int pick = 0;
        iss_valid = allow_issue && ($urandom_range(0, 9) < 8);
        iss_op    = OP_W'($urandom_range(0, 7));
        iss_dst   = REG_W'($urandom_range(0, REG_COUNT - 1));
        iss_src1  = REG_W'($urandom_range(0, REG_COUNT - 1));
        iss_src2  = REG_W'($urandom_range(0, REG_COUNT - 1));
        iss_store = ($urandom_range(0, 7) == 0);
        iss_addr  = ADDR_W'($urandom_range(0, 255));
        rf_val1   = rf[iss_src1];
        rf_val2   = rf[iss_src2];
        for (int t = RS_COUNT; t >= 1; t--) if (m_cd[t] == 0) pick = t;
        cdb_valid = (pick != 0);
        cdb_tag   = TAG_W'(pick);
        cdb_value = (pick != 0) ? m_res[pick] : '0;
    endtask

    task automatic compare();
        int f = exp_free();
        int d = exp_disp();
        int w = exp_wreg();
        chk("R1 R8 iss_ready", 32'(iss_ready), 32'(f != 0));
        if (f != 0) chk("R1 iss_tag", 32'(iss_tag), 32'(f));
        chk("R7 disp_valid", 32'(disp_valid), 32'(d != 0));
        if (d != 0) begin
            chk("R7 disp_tag", 32'(disp_tag), 32'(d));
            chk("R2 R3 R6 R9 disp_vj", 32'(disp_vj), 32'(m_vj[d]));
            chk("R2 R3 R6 R9 disp_vk", 32'(disp_vk), 32'(m_vk[d]));
            chk("R9 disp_op", 32'(disp_op), 32'(m_op[d]));
            chk("R9 disp_addr", 32'(disp_addr), 32'(m_addr[d]));
        end
        // R4 renaming shows up here: only the latest writer of a register updates it
        chk("R5 rf_we", 32'(rf_we), 32'(w >= 0));
        if (w >= 0) begin
            chk("R5 rf_waddr", 32'(rf_waddr), 32'(w));
            chk("R5 rf_wdata", 32'(rf_wdata), 32'(cdb_value));
        end
    endtask

    task automatic step_model();
        int f = exp_free();
        int d = exp_disp();
        int w = exp_wreg();
        int s1 = m_stat[iss_src1];
        int s2 = m_stat[iss_src2];
        int bt = cdb_valid ? int'(cdb_tag) : 0;
        logic [DATA_W-1:0] nvj, nvk;
        int nqj, nqk;
        bit fire = iss_valid && (f != 0);
        // R2 / R3 operand capture using status before this edge
        if (s1 == 0) begin nvj = rf_val1; nqj = 0; end
        else if (s1 == bt) begin nvj = cdb_value; nqj = 0; end
        else begin nvj = '0; nqj = s1; end
        if (s2 == 0) begin nvj = nvj; nvk = rf_val2; nqk = 0; end
        else if (s2 == bt) begin nvk = cdb_value; nqk = 0; end
        else begin nvk = '0; nqk = s2; end
        if (w >= 0) begin rf[w] = cdb_value; m_stat[w] = 0; end
        for (int t = 1; t <= RS_COUNT; t++) if (m_cd[t] > 0) m_cd[t]--;
        if (bt != 0) begin
            for (int t = 1; t <= RS_COUNT; t++) if (m_busy[t]) begin
                if (m_qj[t] == bt) begin m_qj[t] = 0; m_vj[t] = cdb_value; end
                if (m_qk[t] == bt) begin m_qk[t] = 0; m_vk[t] = cdb_value; end
            end
            m_busy[bt] = 0;
            m_cd[bt] = -1;
        end
        if (d != 0) begin
            m_sent[d] = 1;
            m_cd[d] = 1 + (m_op[d] % 4);
            m_res[d] = m_vj[d] + m_vk[d] + DATA_W'(m_op[d]) + DATA_W'(d * 7);
        end
        if (fire) begin
            m_busy[f] = 1; m_sent[f] = 0; m_cd[f] = -1;
            m_op[f] = int'(iss_op); m_addr[f] = int'(iss_addr);
            m_vj[f] = nvj; m_vk[f] = nvk; m_qj[f] = nqj; m_qk[f] = nqk;
            m_seq[f] = seq_ctr++;
            if (!iss_store) m_stat[iss_dst] = f;
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // Reset state: all stations free, nothing dispatched, no register write
        chk("R1 reset iss_ready", 32'(iss_ready), 32'd1);
        chk("R1 reset iss_tag", 32'(iss_tag), 32'd1);
        chk("R7 reset disp_valid", 32'(disp_valid), 32'd0);
        chk("R5 reset rf_we", 32'(rf_we), 32'd0);
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            drive(cyc < 3800);
            #1;
            compare();
            step_model();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule